// File: doc/BRIEF.md
# Network Adapter Host-Bus Glue

This block sits between a 16-bit host bus and an attached network controller on an Ethernet adapter. It claims a 64 KiB window of the 24-bit host byte-address space, placed by a 5-bit select-code switch field, and splits that window into a card identity word, a status/control word, a pass-through port to the controller's register file, a shared packet-buffer RAM and a small parameter memory.

The controller's DMA port reaches the same packet buffer. The two sides share one RAM port, and a host buffer access always wins a same-cycle collision. The controller's active-low interrupt is latched as a pending flag. When interrupts are enabled, the flag drives exactly one of four registered host interrupt lines, which stand for levels 3 to 6. A 2-bit level switch field selects the line.

Host reads return data one cycle after the request. DMA reads return data one cycle after the grant. The buffer depth is `2**BUF_AW` words: 8K words on the full card at BUF_AW=13, and 2K words at the default.

Top module: `lan_host_glue`

## Requirements
- R1: An access is claimed only when host address bits 23:16 equal 0x60 plus `sel_code_i`. An access outside the window gives no `hst_rvalid_o` and changes no state.
- R2: A read of window offset 0x0000 returns 0x0015, with bit 15 set when `remote_i` is high.
- R3: Any write to offset 0x0000 reloads the status word with its reset value, using the current `irq_lvl_i`, and drops every interrupt line at that same edge.
- R4: The status word has lock at bit 0, interrupt enable at bit 1, acknowledge at bit 2, pending at bit 3, the latched level at bits 5:4 and the revision 0x01 at bits 15:8. A write to offset 0x0002 changes only lock and enable. Writing 1 to lock also sets acknowledge. Acknowledge is otherwise sticky until a reset.
- R5: The pending bit equals the inverse of `ctl_irq_ni`, one clock later.
- R6: `irq_o[n]` is high one clock after enable and pending are both set while `irq_lvl_i` equals n. At most one line is high at any time.
- R7: After reset, the status word reads 0x0100 with the level switch value placed in bits 5:4. No interrupt line is high.
- R8: Offsets 0x4000 to 0x4003 reach the controller port, with `ctl_addr_o` taken from address bit 1. Read data comes from `ctl_rdata_i`. Every such access sets acknowledge.
- R9: Offsets 0x8000 to 0xBFFF reach the buffer RAM at word index (offset/2) modulo its depth. Writes honour the byte enables, with bit 0 enabling data bits 7:0.
- R10: A granted DMA access uses word index (byte address/2) modulo the buffer depth and honours the byte enables. Read data follows with `dma_rvalid_o` one clock later.
- R11: When a host buffer access and a DMA request meet in the same cycle, the host is served and `dma_ack_o` stays low for that cycle.
- R12: Offsets 0xC000 to 0xFFFF reach a 64-word parameter memory indexed by offset bits 6:1.
- R13: Reads of unmapped offsets inside the window return 0xFFFF. Writes to them have no effect.
- R14: A claimed host read raises `hst_rvalid_o` for one cycle on the clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_code_i | input | 5 | Window select-code switches |
| irq_lvl_i | input | 2 | Interrupt level switches (level = value + 3) |
| remote_i | input | 1 | Remote switch, seen in the ID word |
| hst_req_i | input | 1 | Host access request, one cycle per access |
| hst_we_i | input | 1 | Host write |
| hst_addr_i | input | 24 | Host byte address |
| hst_be_i | input | 2 | Host byte enables |
| hst_wdata_i | input | 16 | Host write data |
| hst_rvalid_o | output | 1 | Host read data valid |
| hst_rdata_o | output | 16 | Host read data |
| ctl_req_o | output | 1 | Controller register access strobe |
| ctl_we_o | output | 1 | Controller register write |
| ctl_addr_o | output | 1 | Controller register word select |
| ctl_wdata_o | output | 16 | Controller register write data |
| ctl_rdata_i | input | 16 | Controller register read data |
| ctl_irq_ni | input | 1 | Controller interrupt, active low |
| dma_req_i | input | 1 | DMA access request |
| dma_we_i | input | 1 | DMA write |
| dma_addr_i | input | 16 | DMA byte address |
| dma_be_i | input | 2 | DMA byte enables |
| dma_wdata_i | input | 16 | DMA write data |
| dma_ack_o | output | 1 | DMA grant for this cycle |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 16 | DMA read data |
| irq_o | output | 4 | Host interrupt lines, bit n = level n+3 |

## Verification
The hardest case to reach from the ports is a host buffer access and a DMA request that arrive on the same edge. The bench drives both on one falling edge and then watches `dma_ack_o` drop for that cycle and rise on the next. It covers two orders of events. In the first, both sides write the same word and a host read-back must show the DMA value, because the stalled write lands second. In the second, both sides read and each must still receive its own word. The level latched in the status word only moves on a card reset. The bench therefore changes the level switches, issues an ID write, and reads the status word to see the new field.

// File: rtl/lan_glue_pkg.sv
package lan_glue_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_ID,
    RG_STAT,
    RG_CTL,
    RG_BUF,
    RG_PAR
  } region_e;

  localparam int STAT_LOCK = 0;
  localparam int STAT_IE   = 1;
  localparam int STAT_ACK  = 2;
  localparam int STAT_PEND = 3;
  localparam int STAT_LVL  = 4;
endpackage

// File: rtl/lan_win_decode.sv
module lan_win_decode
  import lan_glue_pkg::*;
#(
  parameter int         SEL_W  = 5,
  parameter int         AW     = 24,
  parameter logic [7:0] WIN_HI = 8'h60
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             hit_o,
  output region_e          region_o
);
  localparam int HI_W = AW - 16;

  logic [HI_W-1:0] base;
  logic [15:0]     off;
  logic            unused_lsb;

  assign unused_lsb = off[0];

  always_comb begin
    base     = HI_W'(WIN_HI) + HI_W'(sel_i);
    off      = addr_i[15:0];
    hit_o    = (addr_i[AW-1:16] == base);
    region_o = RG_NONE;
    if (hit_o) begin
      unique case (off[15:14])
        2'b00:   if (off[13:2] == '0) region_o = off[1] ? RG_STAT : RG_ID;
        2'b01:   if (off[13:2] == '0) region_o = RG_CTL;
        2'b10:   region_o = RG_BUF;
        default: region_o = RG_PAR;
      endcase
    end
  end
endmodule

// File: rtl/lan_lane_ram.sv
module lan_lane_ram #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 8,
  parameter int DW    = LANES * LW
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (we_i && be_i[l]) mem[addr_i] <= wdata_i[l*LW +: LW];
        if (!we_i)           q <= mem[addr_i];
      end
    end

    assign rdata_o[l*LW +: LW] = q;
  end
endmodule

// File: rtl/lan_stat_reg.sv
module lan_stat_reg
  import lan_glue_pkg::*;
#(
  parameter int         LVL_W  = 2,
  parameter int         NLINES = 1 << LVL_W,
  parameter logic [7:0] REV    = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  input  logic              ack_set_i,
  input  logic              ctl_irq_ni,
  output logic [15:0]       stat_o,
  output logic [NLINES-1:0] irq_o
);
  logic             lock_q, ie_q, ack_q, pend_q;
  logic [LVL_W-1:0] lvl_q;
  logic             fire;
  logic             unused_wd;

  assign unused_wd = ^wdata_i[15:2];
  assign fire      = ie_q && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
      lvl_q  <= lvl_i;
    end else if (soft_rst_i) begin
      lock_q <= 1'b0;
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
      lvl_q  <= lvl_i;
    end else begin
      pend_q <= ~ctl_irq_ni;
      if (wr_i) begin
        lock_q <= wdata_i[STAT_LOCK];
        ie_q   <= wdata_i[STAT_IE];
      end
      if ((wr_i && wdata_i[STAT_LOCK]) || ack_set_i) ack_q <= 1'b1;
    end
  end

  // Registered routing: switch changes cannot glitch a line
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         irq_o[g] <= 1'b0;
      else if (soft_rst_i) irq_o[g] <= 1'b0;
      else                 irq_o[g] <= fire && (lvl_i == LVL_W'(g));
    end
  end

  always_comb begin
    stat_o                      = '0;
    stat_o[15:8]                = REV;
    stat_o[STAT_LVL +: LVL_W]   = lvl_q;
    stat_o[STAT_PEND]           = pend_q;
    stat_o[STAT_ACK]            = ack_q;
    stat_o[STAT_IE]             = ie_q;
    stat_o[STAT_LOCK]           = lock_q;
  end

  assert_irq_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(ie_q && pend_q));
  assert_lock_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[STAT_LOCK] && !soft_rst_i) |=> ack_q);
  assert_lvl_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_rst_i) |=> $stable(lvl_q));
  assert_ctl_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_set_i && !soft_rst_i) |=> ack_q);
  assert_pend_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> (pend_q == !$past(ctl_irq_ni)));
endmodule

// File: rtl/lan_host_glue.sv
module lan_host_glue
  import lan_glue_pkg::*;
#(
  parameter int          SEL_W   = 5,
  parameter int          LVL_W   = 2,
  parameter int          NLINES  = 1 << LVL_W,
  parameter int          BUF_AW  = 11,
  parameter int          PAR_AW  = 6,
  parameter logic [15:0] CARD_ID = 16'h0015,
  parameter logic [7:0]  REV     = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_code_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic              remote_i,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic [23:0]       hst_addr_i,
  input  logic [1:0]        hst_be_i,
  input  logic [15:0]       hst_wdata_i,
  output logic              hst_rvalid_o,
  output logic [15:0]       hst_rdata_o,
  output logic              ctl_req_o,
  output logic              ctl_we_o,
  output logic              ctl_addr_o,
  output logic [15:0]       ctl_wdata_o,
  input  logic [15:0]       ctl_rdata_i,
  input  logic              ctl_irq_ni,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [15:0]       dma_addr_i,
  input  logic [1:0]        dma_be_i,
  input  logic [15:0]       dma_wdata_i,
  output logic              dma_ack_o,
  output logic              dma_rvalid_o,
  output logic [15:0]       dma_rdata_o,
  output logic [NLINES-1:0] irq_o
);
  logic        hit;
  region_e     region;
  logic        acc, host_buf, par_en, soft_rst, stat_wr;
  logic [15:0] stat, rd_now;
  logic        buf_we;
  logic [BUF_AW-1:0] buf_addr;
  logic [1:0]  buf_be;
  logic [15:0] buf_wd, buf_q, par_q;
  region_e     rsel_q;
  logic [15:0] rhold_q;
  logic        rvalid_q, drvalid_q;
  logic        unused_addr;

  assign unused_addr = ^{dma_addr_i, hst_addr_i[0]};

  lan_win_decode #(.SEL_W(SEL_W), .AW(24), .WIN_HI(8'h60)) u_dec (
    .addr_i  (hst_addr_i),
    .sel_i   (sel_code_i),
    .hit_o   (hit),
    .region_o(region)
  );

  assign acc      = hst_req_i && hit;
  assign soft_rst = acc && hst_we_i && (region == RG_ID);
  assign stat_wr  = acc && hst_we_i && (region == RG_STAT);
  assign host_buf = acc && (region == RG_BUF);
  assign par_en   = acc && (region == RG_PAR);

  assign ctl_req_o   = acc && (region == RG_CTL);
  assign ctl_we_o    = hst_we_i;
  assign ctl_addr_o  = hst_addr_i[1];
  assign ctl_wdata_o = hst_wdata_i;

  lan_stat_reg #(.LVL_W(LVL_W), .NLINES(NLINES), .REV(REV)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .lvl_i     (irq_lvl_i),
    .wr_i      (stat_wr),
    .wdata_i   (hst_wdata_i),
    .ack_set_i (ctl_req_o),
    .ctl_irq_ni(ctl_irq_ni),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  // Host owns the buffer port on collision; DMA retries next cycle
  assign dma_ack_o = dma_req_i && !host_buf;

  always_comb begin
    if (host_buf) begin
      buf_we   = hst_we_i;
      buf_addr = hst_addr_i[BUF_AW:1];
      buf_be   = hst_be_i;
      buf_wd   = hst_wdata_i;
    end else begin
      buf_we   = dma_we_i;
      buf_addr = dma_addr_i[BUF_AW:1];
      buf_be   = dma_be_i;
      buf_wd   = dma_wdata_i;
    end
  end

  lan_lane_ram #(.AW(BUF_AW), .LANES(2), .LW(8)) u_buf (
    .clk_i  (clk_i),
    .en_i   (host_buf || dma_ack_o),
    .we_i   (buf_we),
    .addr_i (buf_addr),
    .be_i   (buf_be),
    .wdata_i(buf_wd),
    .rdata_o(buf_q)
  );

  lan_lane_ram #(.AW(PAR_AW), .LANES(2), .LW(8)) u_par (
    .clk_i  (clk_i),
    .en_i   (par_en),
    .we_i   (hst_we_i),
    .addr_i (hst_addr_i[PAR_AW:1]),
    .be_i   (hst_be_i),
    .wdata_i(hst_wdata_i),
    .rdata_o(par_q)
  );

  always_comb begin
    unique case (region)
      RG_ID:   rd_now = CARD_ID | {remote_i, 15'd0};
      RG_STAT: rd_now = stat;
      RG_CTL:  rd_now = ctl_rdata_i;
      default: rd_now = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q    <= RG_NONE;
      rhold_q   <= 16'hFFFF;
      rvalid_q  <= 1'b0;
      drvalid_q <= 1'b0;
    end else begin
      rvalid_q  <= acc && !hst_we_i;
      drvalid_q <= dma_ack_o && !dma_we_i;
      if (acc && !hst_we_i) begin
        rsel_q  <= region;
        rhold_q <= rd_now;
      end
    end
  end

  assign hst_rvalid_o = rvalid_q;
  assign hst_rdata_o  = (rsel_q == RG_BUF) ? buf_q :
                        (rsel_q == RG_PAR) ? par_q : rhold_q;
  assign dma_rvalid_o = drvalid_q;
  assign dma_rdata_o  = buf_q;

  assert_rvalid_src_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_rvalid_o |-> $past(hst_req_i && !hst_we_i));
  assert_dma_rvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rvalid_o |-> $past(dma_req_i && !dma_we_i));
  assert_ctl_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_req_o |-> (hst_addr_i[15:2] == 14'h1000));
endmodule

// File: tb/lan_host_glue_tb_top.sv
module lan_host_glue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] sel_code = 5'd21;
  logic [1:0] irq_lvl = 2'd2;
  logic remote = 1'b0;
  logic hst_req = 0, hst_we = 0;
  logic [23:0] hst_addr = '0;
  logic [1:0] hst_be = 2'b11;
  logic [15:0] hst_wdata = '0;
  logic hst_rvalid;
  logic [15:0] hst_rdata;
  logic ctl_req, ctl_we, ctl_addr;
  logic [15:0] ctl_wdata, ctl_rdata;
  logic ctl_irq_n = 1'b1;
  logic dma_req = 0, dma_we = 0;
  logic [15:0] dma_addr = '0;
  logic [1:0] dma_be = 2'b11;
  logic [15:0] dma_wdata = '0;
  logic dma_ack, dma_rvalid;
  logic [15:0] dma_rdata;
  logic [3:0] irq;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ctl_rdata = 16'hC0DE ^ {15'd0, ctl_addr};

  lan_host_glue dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_code_i(sel_code), .irq_lvl_i(irq_lvl),
    .remote_i(remote), .hst_req_i(hst_req), .hst_we_i(hst_we), .hst_addr_i(hst_addr),
    .hst_be_i(hst_be), .hst_wdata_i(hst_wdata), .hst_rvalid_o(hst_rvalid),
    .hst_rdata_o(hst_rdata), .ctl_req_o(ctl_req), .ctl_we_o(ctl_we),
    .ctl_addr_o(ctl_addr), .ctl_wdata_o(ctl_wdata), .ctl_rdata_i(ctl_rdata),
    .ctl_irq_ni(ctl_irq_n), .dma_req_i(dma_req), .dma_we_i(dma_we),
    .dma_addr_i(dma_addr), .dma_be_i(dma_be), .dma_wdata_i(dma_wdata),
    .dma_ack_o(dma_ack), .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] base(input logic [4:0] s);
    return 24'h600000 + (24'(s) << 16);
  endfunction

  function automatic logic [15:0] stat_exp(input logic [1:0] lv, input bit pend,
                                           input bit ack, input bit ie, input bit lock);
    return 16'h0100 | (16'(lv) << 4) | (16'(pend) << 3) | (16'(ack) << 2)
           | (16'(ie) << 1) | 16'(lock);
  endfunction

  function automatic logic [15:0] pat(input int w);
    return 16'(w * 16'h9E37) ^ 16'h1234;
  endfunction

  task automatic host_wr(input logic [23:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    hst_req = 1; hst_we = 1; hst_addr = a; hst_be = be; hst_wdata = d;
    @(negedge clk);
    hst_req = 0; hst_we = 0;
  endtask

  task automatic host_rd(input logic [23:0] a, output logic [15:0] d, output logic v);
    @(negedge clk);
    hst_req = 1; hst_we = 0; hst_addr = a;
    @(negedge clk);
    hst_req = 0;
    v = hst_rvalid; d = hst_rdata;
  endtask

  task automatic dma_wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    dma_req = 1; dma_we = 1; dma_addr = a; dma_be = be; dma_wdata = d;
    @(negedge clk);
    dma_req = 0; dma_we = 0;
  endtask

  task automatic dma_rd(input logic [15:0] a, output logic [15:0] d, output logic v);
    @(negedge clk);
    dma_req = 1; dma_we = 0; dma_addr = a;
    @(negedge clk);
    dma_req = 0;
    v = dma_rvalid; d = dma_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    logic v;
    logic [23:0] b;
    repeat (3) @(negedge clk);
    chk("R7 irq after reset", {12'd0, irq}, 16'd0);
    chk("R14 rvalid in reset", {15'd0, hst_rvalid}, 16'd0);
    rst_ni = 1;

    // R1/R2: sweep every select code, both remote settings, wrong window
    for (int s = 0; s < 32; s++) begin
      sel_code = 5'(s);
      remote = s[0];
      host_rd(base(5'(s)), d, v);
      chk("R1 hit valid", {15'd0, v}, 16'd1);
      chk("R2 id word", d, 16'h0015 | (s[0] ? 16'h8000 : 16'h0));
      host_rd(base(5'(s)) ^ 24'h010000, d, v);
      chk("R1 miss valid", {15'd0, v}, 16'd0);
    end
    sel_code = 5'd21; remote = 0;
    b = base(5'd21);

    host_rd(b + 2, d, v);
    chk("R7 status reset", d, stat_exp(2'd2, 0, 0, 0, 0));

    // R4: only lock/enable written; lock sets sticky acknowledge
    host_wr(b + 2, 2'b11, 16'hFFF0);
    host_rd(b + 2, d, v);
    chk("R4 other bits kept", d, stat_exp(2'd2, 0, 0, 0, 0));
    host_wr(b + 2, 2'b11, 16'h0002);
    host_rd(b + 2, d, v);
    chk("R4 ie only", d, stat_exp(2'd2, 0, 0, 1, 0));
    host_wr(b + 2, 2'b11, 16'hFFFD);
    host_rd(b + 2, d, v);
    chk("R4 lock sets ack", d, stat_exp(2'd2, 0, 1, 0, 1));
    host_wr(b + 2, 2'b11, 16'h0000);
    host_rd(b + 2, d, v);
    chk("R4 ack sticky", d, stat_exp(2'd2, 0, 1, 0, 0));

    // R3: ID write reloads status with the current level switches
    irq_lvl = 2'd3;
    host_wr(b, 2'b11, 16'h1234);
    host_rd(b + 2, d, v);
    chk("R3 soft reset level", d, stat_exp(2'd3, 0, 0, 0, 0));
    irq_lvl = 2'd2;
    host_wr(b, 2'b11, 16'h0000);
    host_rd(b + 2, d, v);
    chk("R3 soft reset level back", d, stat_exp(2'd2, 0, 0, 0, 0));

    // R5/R6: routing sweep over all levels
    host_wr(b + 2, 2'b11, 16'h0002);
    for (int lv = 0; lv < 4; lv++) begin
      irq_lvl = 2'(lv);
      @(negedge clk); ctl_irq_n = 0;
      @(negedge clk);
      chk("R6 line registered", {12'd0, irq}, 16'd0);
      @(negedge clk);
      chk("R6 line routed", {12'd0, irq}, 16'(1 << lv));
      host_rd(b + 2, d, v);
      chk("R5 pending set", d, stat_exp(2'd2, 1, 0, 1, 0));
      ctl_irq_n = 1;
      @(negedge clk); @(negedge clk);
      chk("R6 line released", {12'd0, irq}, 16'd0);
      host_rd(b + 2, d, v);
      chk("R5 pending cleared", d, stat_exp(2'd2, 0, 0, 1, 0));
    end
    irq_lvl = 2'd2;
    @(negedge clk); ctl_irq_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R6 level 5 line", {12'd0, irq}, 16'h0004);
    host_wr(b, 2'b11, 16'h0000);
    chk("R3 soft reset drops irq", {12'd0, irq}, 16'd0);
    @(negedge clk); @(negedge clk);
    chk("R6 disabled no line", {12'd0, irq}, 16'd0);
    host_rd(b + 2, d, v);
    chk("R5 pending while disabled", d, stat_exp(2'd2, 1, 0, 0, 0));
    ctl_irq_n = 1;
    @(negedge clk);

    // R8: controller pass-through
    host_wr(b, 2'b11, 16'h0000);
    @(negedge clk);
    hst_req = 1; hst_we = 1; hst_addr = b + 24'h4002; hst_wdata = 16'h5AA5;
    #1;
    chk("R8 strobe", {13'd0, ctl_req, ctl_we, ctl_addr}, 16'h0007);
    chk("R8 wdata", ctl_wdata, 16'h5AA5);
    @(negedge clk);
    hst_req = 0; hst_we = 0;
    host_rd(b + 2, d, v);
    chk("R8 ack set by access", d, stat_exp(2'd2, 0, 1, 0, 0));
    host_rd(b + 24'h4000, d, v);
    chk("R8 read word 0", d, 16'hC0DE);
    host_rd(b + 24'h4002, d, v);
    chk("R8 read word 1", d, 16'hC0DF);

    // R13: unmapped
    @(negedge clk);
    hst_req = 1; hst_we = 0; hst_addr = b + 24'h4004;
    #1;
    chk("R13 no ctl strobe", {15'd0, ctl_req}, 16'd0);
    @(negedge clk);
    hst_req = 0;
    chk("R13 unmapped read", hst_rdata, 16'hFFFF);
    host_rd(b + 24'h0004, d, v);
    chk("R13 unmapped low", d, 16'hFFFF);
    host_wr(b + 24'h0006, 2'b11, 16'h0003);
    host_rd(b + 2, d, v);
    chk("R13 unmapped write ignored", d, stat_exp(2'd2, 0, 1, 0, 0));

    // R9/R10: full buffer sweep host -> DMA, then DMA -> host
    for (int w = 0; w < DEPTH; w++) host_wr(b + 24'h8000 + 24'(2 * w), 2'b11, pat(w));
    for (int w = 0; w < DEPTH; w++) begin
      dma_rd(16'(2 * w), d, v);
      if (!v) chk("R10 dma rvalid", 16'(v), 16'd1);
      chk("R10 dma read", d, pat(w));
    end
    for (int w = 0; w < DEPTH; w += 7) dma_wr(16'(2 * w), 2'b11, ~pat(w));
    for (int w = 0; w < DEPTH; w += 7) begin
      host_rd(b + 24'h8000 + 24'(2 * w), d, v);
      chk("R9 host read of dma data", d, ~pat(w));
    end
    host_wr(b + 24'h8000 + 24'(2 * 3), 2'b01, 16'hABCD);
    host_rd(b + 24'h8006, d, v);
    chk("R9 low lane only", d, {pat(3)[15:8], 8'hCD});
    dma_wr(16'(2 * 5), 2'b10, 16'h77EE);
    dma_rd(16'(2 * 5), d, v);
    chk("R10 high lane only", d, {8'h77, pat(5)[7:0]});
    host_rd(b + 24'h8000 + 24'(2 * (DEPTH + 1)), d, v);
    chk("R9 index wraps", d, pat(1));
    dma_rd(16'(2 * (DEPTH + 2)), d, v);
    chk("R10 index wraps", d, pat(2));

    // R11: same-cycle collisions
    @(negedge clk);
    hst_req = 1; hst_we = 1; hst_addr = b + 24'h8000 + 24'(2 * 9); hst_wdata = 16'h1111;
    dma_req = 1; dma_we = 1; dma_addr = 16'(2 * 9); dma_wdata = 16'h2222; dma_be = 2'b11;
    #1;
    chk("R11 dma stalled", {15'd0, dma_ack}, 16'd0);
    @(negedge clk);
    hst_req = 0; hst_we = 0;
    #1;
    chk("R11 dma granted next", {15'd0, dma_ack}, 16'd1);
    @(negedge clk);
    dma_req = 0; dma_we = 0;
    host_rd(b + 24'h8012, d, v);
    chk("R11 dma write lands last", d, 16'h2222);
    @(negedge clk);
    hst_req = 1; hst_addr = b + 24'h8012;
    dma_req = 1; dma_addr = 16'(2 * 4);
    #1;
    chk("R11 read collision stall", {15'd0, dma_ack}, 16'd0);
    @(negedge clk);
    hst_req = 0;
    chk("R11 host data", hst_rdata, 16'h2222);
    @(negedge clk);
    dma_req = 0;
    chk("R11 dma data", {dma_rvalid ? 16'd0 : 16'hDEAD} ^ dma_rdata, pat(4));

    // R12: parameter memory sweep and aliasing
    for (int k = 0; k < 64; k++) host_wr(b + 24'hC000 + 24'(2 * k), 2'b11, 16'(k * 257 + 3));
    for (int k = 0; k < 64; k++) begin
      host_rd(b + 24'hC000 + 24'(2 * k), d, v);
      chk("R12 param read", d, 16'(k * 257 + 3));
    end
    host_wr(b + 24'hC000 + 24'(2 * (64 + 10)), 2'b11, 16'hBEEF);
    host_rd(b + 24'hC000 + 24'(2 * 10), d, v);
    chk("R12 param alias", d, 16'hBEEF);
    host_rd(b + 24'hFFFE, d, v);
    chk("R12 param top", d, 16'(63 * 257 + 3));

    repeat (2) @(negedge clk);
    summary();
  end
endmodule